// File: doc/BRIEF.md
# Two-Stage SD Bus Clock Generator

This block derives the card bus clock from a fast module clock, normally somewhere between 20 and 100 MHz. The first stage is an integer prescaler. It counts module cycles and produces an internal clock of 20 MHz or less. A prescale value of N gives an internal clock at the module clock divided by 2N. The second stage takes a 3-bit rate code `c` and divides that internal clock by 2 to the power `c`. Code 0 passes the internal clock through unchanged. As an example, with a 13 MHz internal clock, code 5 gives 406.25 kHz.

Each phase of the output, high or low, therefore lasts N·2^c module cycles. The output is a registered clock level for the card clock pin. It comes with one-cycle strobes that mark its rising and falling transitions, so the data path can sample or launch on them. Prescale and rate settings are static inputs. They are captured only at a period boundary, which is a rising transition.

A stop input lets the data path pause the bus clock for flow control, for example while a buffer fills or drains. The stop is honoured only at the end of a complete low phase, so the pin freezes low and no shortened pulse ever appears. Releasing the stop starts a fresh, full period on the next module clock edge.

Top module: `sdclk_gen`

## Requirements
- R1: While reset is asserted, and after it until the first edge that sees `stop_i` low, `sd_clk_o`, `rise_o` and `fall_o` are 0 and `halted_o` is 1.
- R2: With prescale N (1..15) and rate code c, every high phase and every low phase lasts exactly N·2^c module clock cycles.
- R3: With prescale 1 and code 0, `sd_clk_o` toggles on every module clock edge, giving a period of two cycles.
- R4: A prescale value of 0 produces exactly the same phase lengths as a prescale value of 1.
- R5: A change of `presc_i` or `rate_i` does not alter the period in progress; it takes effect from the next rising transition, whether the change arrives in the high or the low phase.
- R6: `stop_i` is acted on only at the end of a low phase. If it is high there, the output stays low and `halted_o` rises on that edge. A stop raised during the high phase neither shortens that phase nor the following low phase.
- R7: While halted with `stop_i` high, `sd_clk_o` stays low and neither strobe fires.
- R8: When halted, the first clock edge that samples `stop_i` low raises `sd_clk_o` and clears `halted_o`. The new period uses the settings present at that edge.
- R9: `rise_o` is 1 exactly in the first cycle in which `sd_clk_o` is high, and `fall_o` is 1 exactly in the first cycle in which it is low after a high phase. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_i | input | PRESC_W (4) | First-stage prescale value; 0 acts as 1 |
| rate_i | input | RATE_W (3) | Second-stage rate code, divide by 2^code |
| stop_i | input | 1 | Request to park the bus clock low |
| sd_clk_o | output | 1 | Card bus clock level |
| rise_o | output | 1 | Strobe in the first high cycle of the bus clock |
| fall_o | output | 1 | Strobe in the first low cycle of the bus clock |
| halted_o | output | 1 | Bus clock is parked low |

## Verification
The assertions assume that `stop_i`, `presc_i` and `rate_i` are synchronous to `clk`. They also assume the settings may move at any time, since the design captures them only at a rising transition. The phase-length property compares each completed phase against the settings captured for that period, not against the live inputs.

The stimulus drives every input half a cycle away from the clock edge. It changes settings only at points whose position in the period it knows: just after a rising or a falling transition. This lets it predict each transition interval without modelling the counters. Stop is raised during a high phase and released only after a parked interval, which covers both the boundary rule and the resume rule.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Effective first-stage divisor: a programmed zero behaves as one.
  function automatic int unsigned presc_eff(input int unsigned p);
    return (p == 0) ? 32'd1 : p;
  endfunction

  // Second-stage divisor selected by the rate code.
  function automatic int unsigned rate_div(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Module cycles spent in one phase (high or low) of the bus clock.
  function automatic int unsigned half_period(input int unsigned p,
                                              input int unsigned code);
    return presc_eff(p) * rate_div(code);
  endfunction

endpackage

// File: rtl/sdclk_prescaler.sv
module sdclk_prescaler #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_w;

  assign last_w = PW'(sdclk_pkg::presc_eff(32'(presc_i)) - 32'd1);
  assign tick_o = (cnt_q == last_w);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + PW'(1);
  end

  // R2: the prescale count never runs past the captured terminal value
  p_presc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_w);

endmodule

// File: rtl/sdclk_rate_div.sv
module sdclk_rate_div #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [CW-1:0] code_i,
  output logic          phase_end_o
);
  localparam int DW = (1 << CW) - 1;

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] term_w;

  // Terminal count 2^code - 1 built as a thermometer code.
  generate
    for (genvar i = 0; i < DW; i++) begin : g_term
      assign term_w[i] = (code_i > CW'(i));
    end
  endgenerate

  assign phase_end_o = tick_i && (cnt_q == term_w);

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (restart_i || phase_end_o) cnt_q <= '0;
    else if (tick_i)                   cnt_q <= cnt_q + DW'(1);
  end

  // R2: the rate count stays within 2^code - 1
  p_rate_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= term_w);

endmodule

// File: rtl/sdclk_phase_ctl.sv
module sdclk_phase_ctl #(
  parameter int PW = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_i,
  input  logic [PW-1:0] presc_i,
  input  logic [CW-1:0] rate_i,
  input  logic          phase_end_i,
  output logic [PW-1:0] act_presc_o,
  output logic [CW-1:0] act_rate_o,
  output logic          restart_o,
  output logic          clk_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic          halted_o
);
  localparam int DW = (1 << CW) - 1;
  localparam int LW = PW + DW + 1;

  logic          clk_q, halted_q, rise_q, fall_q;
  logic [PW-1:0] act_presc_q;
  logic [CW-1:0] act_rate_q;

  // Named events
  logic boundary_go, to_low, to_halt;
  assign boundary_go = !stop_i && (halted_q || (phase_end_i && !clk_q));
  assign to_low      = phase_end_i && clk_q;
  assign to_halt     = stop_i && !halted_q && phase_end_i && !clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q       <= 1'b0;
      halted_q    <= 1'b1;
      rise_q      <= 1'b0;
      fall_q      <= 1'b0;
      act_presc_q <= '0;
      act_rate_q  <= '0;
    end else begin
      rise_q <= boundary_go;
      fall_q <= to_low;
      if (boundary_go) begin
        clk_q       <= 1'b1;
        halted_q    <= 1'b0;
        act_presc_q <= presc_i;
        act_rate_q  <= rate_i;
      end else if (to_low) begin
        clk_q <= 1'b0;
      end else if (to_halt) begin
        halted_q <= 1'b1;
      end
    end
  end

  assign restart_o   = boundary_go;
  assign clk_o       = clk_q;
  assign rise_o      = rise_q;
  assign fall_o      = fall_q;
  assign halted_o    = halted_q;
  assign act_presc_o = act_presc_q;
  assign act_rate_o  = act_rate_q;

  // Phase-length observer for the assertions
  logic [LW-1:0] chk_len;
  logic [LW-1:0] half_w;
  assign half_w = LW'(sdclk_pkg::half_period(32'(act_presc_q), 32'(act_rate_q)));

  always_ff @(posedge clk) begin
    if (!rst_n)                    chk_len <= '0;
    else if (boundary_go || to_low) chk_len <= LW'(1);
    else if (chk_len != '1)         chk_len <= chk_len + LW'(1);
  end

  // R2: each completed phase lasts exactly prescale * 2^code cycles
  p_phase_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end_i && !halted_q) |-> (chk_len == half_w));

  // R5: captured settings move only with a rising transition
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(clk_q) |-> ($stable(act_presc_q) && $stable(act_rate_q)));

  // R6: a parked clock stays parked while stop is held
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && stop_i) |=> (halted_q && !clk_q));

  // R8: a rising transition requires stop low on the edge that made it
  p_rise_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_q) |-> !$past(stop_i));

  // R9: strobes follow the level they announce
  p_rise_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (clk_q && !halted_q));
  p_fall_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !clk_q);

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen #(
  parameter int PRESC_W = 4,
  parameter int RATE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [RATE_W-1:0]  rate_i,
  input  logic               stop_i,
  output logic               sd_clk_o,
  output logic               rise_o,
  output logic               fall_o,
  output logic               halted_o
);
  logic               tick;
  logic               phase_end;
  logic               restart;
  logic [PRESC_W-1:0] act_presc;
  logic [RATE_W-1:0]  act_rate;

  sdclk_prescaler #(.PW(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .presc_i   (act_presc),
    .tick_o    (tick)
  );

  sdclk_rate_div #(.CW(RATE_W)) u_rate (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart_i   (restart),
    .tick_i      (tick),
    .code_i      (act_rate),
    .phase_end_o (phase_end)
  );

  sdclk_phase_ctl #(.PW(PRESC_W), .CW(RATE_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .presc_i     (presc_i),
    .rate_i      (rate_i),
    .phase_end_i (phase_end),
    .act_presc_o (act_presc),
    .act_rate_o  (act_rate),
    .restart_o   (restart),
    .clk_o       (sd_clk_o),
    .rise_o      (rise_o),
    .fall_o      (fall_o),
    .halted_o    (halted_o)
  );

  // R7: a parked clock is low and silent
  p_halt_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!sd_clk_o && !rise_o));

  // R9: never both strobes in one cycle
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

endmodule

// File: tb/sim_sdclk_gen.sv
`timescale 1ns/1ps
module sim_sdclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] presc_i = 4'd1;
  logic [2:0] rate_i = 3'd0;
  logic       stop_i = 1'b1;
  logic       sd_clk_o, rise_o, fall_o, halted_o;

  always #4 clk = ~clk;

  sdclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .presc_i(presc_i), .rate_i(rate_i),
    .stop_i(stop_i), .sd_clk_o(sd_clk_o), .rise_o(rise_o),
    .fall_o(fall_o), .halted_o(halted_o)
  );

  typedef struct {
    bit    rise;
    int    val;
    bit    absolute;
    string req;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   cyc = 0;
  int   last_edge = 0;
  int   hcur = 1;
  bit   prev = 1'b0;
  bit   mon_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic int half_of(input int p, input int c);
    int n;
    n = (p == 0) ? 1 : p;
    return n * (2 ** c);
  endfunction

  task automatic push_edge(input bit r, input int v, input bit ab, input string req);
    q.push_back('{rise: r, val: v, absolute: ab, req: req});
  endtask

  task automatic push_periods(input int h, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      push_edge(1'b0, h, 1'b0, req);
      push_edge(1'b1, h, 1'b0, req);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) begin
      @(negedge clk); #1;
    end
  endtask

  // Monitor: compares observed transitions against the queue of expectations
  always @(negedge clk) begin
    if (mon_en) begin
      if (sd_clk_o !== prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "unexpected transition, level", int'(sd_clk_o), int'(prev));
        end else begin
          exp_t it;
          int   got;
          it  = q.pop_front();
          got = it.absolute ? cyc : (cyc - last_edge);
          check(sd_clk_o == it.rise, it.req, "transition direction", int'(sd_clk_o), int'(it.rise));
          check(got == it.val, it.req, it.absolute ? "transition cycle" : "phase length", got, it.val);
        end
        if (sd_clk_o) check(rise_o && !fall_o, "R9", "strobes at rise {rise,fall}",
                            int'({rise_o, fall_o}), 2);
        else          check(fall_o && !rise_o, "R9", "strobes at fall {rise,fall}",
                            int'({rise_o, fall_o}), 1);
        last_edge = cyc;
        prev      = sd_clk_o;
      end else begin
        check(!rise_o && !fall_o, "R9", "strobe without transition",
              int'({rise_o, fall_o}), 0);
      end
    end
  end

  // Rest of the current period with old settings, then new periods (R5)
  task automatic reconfig_high(input int p, input int c, input int n, input string req);
    push_edge(1'b0, hcur, 1'b0, "R5");
    push_edge(1'b1, hcur, 1'b0, "R5");
    presc_i = 4'(p);
    rate_i  = 3'(c);
    hcur    = half_of(p, c);
    push_periods(hcur, n, req);
    drain();
  endtask

  task automatic reconfig_low(input int p, input int c, input int n, input string req);
    push_edge(1'b0, hcur, 1'b0, "R5");
    drain();
    presc_i = 4'(p);
    rate_i  = 3'(c);
    push_edge(1'b1, hcur, 1'b0, "R5");
    hcur = half_of(p, c);
    push_periods(hcur, n, req);
    drain();
  endtask

  task automatic resume(input int n, input string req);
    stop_i = 1'b0;
    hcur = half_of(int'(presc_i), int'(rate_i));
    push_edge(1'b1, cyc + 1, 1'b1, "R8");
    push_periods(hcur, n, req);
    @(negedge clk); #1;
    check(sd_clk_o == 1'b1, "R8", "level after release", int'(sd_clk_o), 1);
    check(halted_o == 1'b0, "R8", "halted after release", int'(halted_o), 0);
    drain();
  endtask

  task automatic run_all();
    // R1: reset values
    repeat (3) begin
      @(negedge clk); #1;
      check(!sd_clk_o && !rise_o && !fall_o, "R1", "outputs in reset",
            int'({sd_clk_o, rise_o, fall_o}), 0);
      check(halted_o, "R1", "halted in reset", int'(halted_o), 1);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;
    repeat (5) begin
      @(negedge clk); #1;
      check(!sd_clk_o && halted_o, "R1", "parked after reset {clk,halted}",
            int'({sd_clk_o, halted_o}), 1);
    end
    // R3: pass-through with prescale 1, code 0
    resume(4, "R3");
    // R4: prescale 0 equals prescale 1
    reconfig_high(0, 2, 3, "R4");
    reconfig_high(1, 2, 2, "R4");
    // R2: several prescale / code pairs
    reconfig_high(3, 1, 3, "R2");
    reconfig_high(5, 3, 2, "R2");
    reconfig_high(2, 7, 2, "R2");
    // R5: change arriving in the low phase
    reconfig_low(1, 5, 2, "R5");
    // R6: stop raised in the high phase
    push_edge(1'b0, hcur, 1'b0, "R6");
    stop_i = 1'b1;
    drain();
    repeat (hcur - 1) @(negedge clk);
    check(halted_o == 1'b0, "R6", "halted before low phase ends", int'(halted_o), 0);
    @(negedge clk);
    check(halted_o == 1'b1, "R6", "halted at end of low phase", int'(halted_o), 1);
    check(sd_clk_o == 1'b0, "R6", "parked level", int'(sd_clk_o), 0);
    // R7: stays parked; settings change while parked
    presc_i = 4'd4;
    rate_i  = 3'd1;
    repeat (20) @(negedge clk);
    #1;
    check(!sd_clk_o && halted_o, "R7", "still parked {clk,halted}",
          int'({sd_clk_o, halted_o}), 1);
    // R8: release uses the current settings
    resume(3, "R8");
    check(q.size() == 0, "R2", "pending expectations", q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired, pending", q.size(), 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule